// File: doc/BRIEF.md
# Receive DDR Sample Framer

This block sits at the transmit end of the receive data path of a source-synchronous sample link. The link has six data lanes and moves data on both edges of the interface clock. Each 12-bit sample word offered on a valid/ready stream is cut into two 6-bit halves. The upper half is placed in the rising-edge slot of one interface clock cycle and the lower half in the falling-edge slot of the same cycle. A frame strobe travels beside the data, with one level per edge slot. A low-to-high transition of the strobe tells the far end that a frame, here one sample word, begins. The far end relies on the strobe to separate valid words from filler.

Two plain control pulses open and close a burst. A stream word is accepted only inside a burst. Slots that carry no accepted word are driven with zero lanes and a low strobe, so every output has a defined level at all times. The strobe has two forms, chosen at the start of each burst:
- **Level form:** the strobe stays high across a run of back-to-back words, so a contiguous run shows a single rising edge.
- **Pulse form:** the strobe is a 50% square wave, high for the rising-edge half and low for the falling-edge half of every word.

Back-pressure rules: `s_ready` is high exactly while a burst is open and depends only on state, never on `s_valid`. A word transfers on a clock edge where both `s_valid` and `s_ready` are high. The producer may hold or change `s_data` freely while `s_ready` is low. There is no storage, so no accepted word is ever delayed by more than one cycle or dropped.

Top module: `rxddr_framer`

## Requirements
- R1: For an accepted word, `lane_rise[i]` equals word bit i+6 and `lane_fall[i]` equals word bit i, for i = 0..5.
- R2: An accepted word appears on the outputs in the clock cycle that directly follows its handshake edge.
- R3: `s_ready` is high exactly while a burst is open. A `burst_start` pulse while closed opens the burst from the next cycle. A `burst_end` pulse while open closes it from the next cycle. The word offered in the `burst_end` cycle is still accepted.
- R4: With `cfg_pulse_mode`=0 latched (level form), a slot carrying an accepted word has `strb_rise`=1 and `strb_fall`=1.
- R5: With `cfg_pulse_mode`=1 latched (pulse form), a slot carrying an accepted word has `strb_rise`=1 and `strb_fall`=0.
- R6: A slot with no accepted word has both lane buses at zero and both strobe bits at 0.
- R7: `cfg_pulse_mode` is sampled only on the cycle that opens a burst. Changes during an open burst have no effect on the strobe form until the next burst.
- R8: `burst_start` while open and `burst_end` while closed are ignored. `s_valid` while closed moves no word to the outputs.
- R9: While `rst_n` is low, `s_ready` is 0 and all lane and strobe outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; one rising and one falling slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pulse_mode | input | 1 | Strobe form for the next burst: 0 level, 1 pulse |
| burst_start | input | 1 | Pulse that opens a burst |
| burst_end | input | 1 | Pulse that closes the open burst |
| s_valid | input | 1 | Sample word offered |
| s_ready | output | 1 | Word can be accepted (burst open) |
| s_data | input | 12 | Sample word |
| lane_rise | output | 6 | Lane values for the rising-edge slot |
| lane_fall | output | 6 | Lane values for the falling-edge slot |
| strb_rise | output | 1 | Frame strobe level in the rising-edge slot |
| strb_fall | output | 1 | Frame strobe level in the falling-edge slot |

## Verification
A stale burst flag appears at `s_ready` in the very next cycle: either words are refused inside a burst, or filler is accepted after the end pulse. A wrong latched strobe form appears at `strb_fall` on the first word of the burst. A swapped or shifted half-word appears on the lanes one cycle after the handshake. A missing zeroing path leaves nonzero lanes or a high strobe in the first idle slot after a word. The bench runs a reference model of the burst state and the latched form beside random handshakes, and compares every slot against it.

// File: rtl/rxddr_pkg.sv
package rxddr_pkg;

  typedef enum logic {
    FRM_LEVEL = 1'b0,
    FRM_PULSE = 1'b1
  } frame_form_e;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
  } strobe_pair_t;

  localparam strobe_pair_t STROBE_IDLE = '{on_rise: 1'b0, on_fall: 1'b0};

endpackage

// File: rtl/rxddr_burst_ctrl.sv
module rxddr_burst_ctrl
  import rxddr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_pulse_mode,
  input  logic        burst_start,
  input  logic        burst_end,
  output logic        burst_open,
  output frame_form_e form_q
);

  logic        open_d;
  frame_form_e form_d;

  always_comb begin
    open_d = burst_open;
    form_d = form_q;
    if (burst_open) begin
      if (burst_end) open_d = 1'b0;
    end else if (burst_start) begin
      open_d = 1'b1;
      form_d = cfg_pulse_mode ? FRM_PULSE : FRM_LEVEL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_open <= 1'b0;
      form_q     <= FRM_LEVEL;
    end else begin
      burst_open <= open_d;
      form_q     <= form_d;
    end
  end

endmodule

// File: rtl/rxddr_word_split.sv
module rxddr_word_split #(
  parameter int LANES    = 6,
  parameter bit HI_FIRST = 1'b1
) (
  input  logic [2*LANES-1:0] word,
  input  logic               take,
  output logic [LANES-1:0]   half_rise,
  output logic [LANES-1:0]   half_fall
);

  localparam int WORD_W = 2 * LANES;

  logic [LANES-1:0] upper;
  logic [LANES-1:0] lower;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign upper[g] = take & word[g + LANES];
    assign lower[g] = take & word[g];
  end

  if (HI_FIRST) begin : g_hi_first
    assign half_rise = upper;
    assign half_fall = lower;
  end else begin : g_lo_first
    assign half_rise = lower;
    assign half_fall = upper;
  end

  if (WORD_W != 2 * LANES) begin : g_bad_width
    $error("word width must be twice the lane count");
  end

endmodule

// File: rtl/rxddr_strobe_gen.sv
module rxddr_strobe_gen
  import rxddr_pkg::*;
(
  input  logic         take,
  input  frame_form_e  form,
  output strobe_pair_t strobe
);

  always_comb begin
    strobe = STROBE_IDLE;
    if (take) begin
      strobe.on_rise = 1'b1;
      strobe.on_fall = (form == FRM_LEVEL);
    end
  end

endmodule

// File: rtl/rxddr_framer.sv
module rxddr_framer
  import rxddr_pkg::*;
#(
  parameter int LANES = 6,
  localparam int WORD_W = 2 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pulse_mode,
  input  logic              burst_start,
  input  logic              burst_end,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic [LANES-1:0]  lane_rise,
  output logic [LANES-1:0]  lane_fall,
  output logic              strb_rise,
  output logic              strb_fall
);

  logic             burst_open;
  frame_form_e      form_q;
  logic             take;
  logic [LANES-1:0] half_rise;
  logic [LANES-1:0] half_fall;
  strobe_pair_t     strobe_d;

  rxddr_burst_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_pulse_mode (cfg_pulse_mode),
    .burst_start    (burst_start),
    .burst_end      (burst_end),
    .burst_open     (burst_open),
    .form_q         (form_q)
  );

  assign s_ready = burst_open;
  assign take    = s_valid & burst_open;

  rxddr_word_split #(
    .LANES    (LANES),
    .HI_FIRST (1'b1)
  ) u_split (
    .word      (s_data),
    .take      (take),
    .half_rise (half_rise),
    .half_fall (half_fall)
  );

  rxddr_strobe_gen u_strobe (
    .take   (take),
    .form   (form_q),
    .strobe (strobe_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_rise <= '0;
      lane_fall <= '0;
      strb_rise <= 1'b0;
      strb_fall <= 1'b0;
    end else begin
      lane_rise <= half_rise;
      lane_fall <= half_fall;
      strb_rise <= strobe_d.on_rise;
      strb_fall <= strobe_d.on_fall;
    end
  end

endmodule

// File: rtl/rxddr_framer_chk.sv
module rxddr_framer_chk #(
  parameter int LANES = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_pulse_mode,
  input logic               burst_start,
  input logic               burst_end,
  input logic               s_valid,
  input logic               s_ready,
  input logic [2*LANES-1:0] s_data,
  input logic [LANES-1:0]   lane_rise,
  input logic [LANES-1:0]   lane_fall,
  input logic               strb_rise,
  input logic               strb_fall
);

  a_r1_split_order: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=>
      (lane_rise == $past(s_data[2*LANES-1:LANES]) &&
       lane_fall == $past(s_data[LANES-1:0])));

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> strb_rise);

  a_r3_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && burst_start) |=> s_ready);

  a_r3_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && burst_end) |=> !s_ready);

  a_r8_no_spurious_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !burst_start) |=> !s_ready);

  a_r6_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=>
      (lane_rise == '0 && lane_fall == '0 && !strb_rise && !strb_fall));

  a_r4_fall_implies_rise: assert property (@(posedge clk) disable iff (!rst_n)
    strb_fall |-> strb_rise);

  // R7: the strobe form cannot change between words of one open burst
  a_r7_form_held: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && $past(s_ready) && strb_rise && $past(strb_rise)) |->
      (strb_fall == $past(strb_fall)));

  logic unused_cfg;
  assign unused_cfg = cfg_pulse_mode;

endmodule

bind rxddr_framer rxddr_framer_chk #(.LANES(LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_pulse_mode (cfg_pulse_mode),
  .burst_start    (burst_start),
  .burst_end      (burst_end),
  .s_valid        (s_valid),
  .s_ready        (s_ready),
  .s_data         (s_data),
  .lane_rise      (lane_rise),
  .lane_fall      (lane_fall),
  .strb_rise      (strb_rise),
  .strb_fall      (strb_fall)
);

// File: tb/rxddr_framer_test.sv
module rxddr_framer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pulse_mode = 1'b0;
  logic        burst_start = 1'b0;
  logic        burst_end = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic [5:0]  lane_rise;
  logic [5:0]  lane_fall;
  logic        strb_rise;
  logic        strb_fall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit m_open = 1'b0;
  bit m_pulse = 1'b0;

  always #4 clk = ~clk;

  rxddr_framer uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_pulse_mode (cfg_pulse_mode),
    .burst_start    (burst_start),
    .burst_end      (burst_end),
    .s_valid        (s_valid),
    .s_ready        (s_ready),
    .s_data         (s_data),
    .lane_rise      (lane_rise),
    .lane_fall      (lane_fall),
    .strb_rise      (strb_rise),
    .strb_fall      (strb_fall)
  );

  task automatic check(input string tag, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_upper(input logic [11:0] w);
    return w[11:6];
  endfunction

  function automatic logic [5:0] exp_lower(input logic [11:0] w);
    return w[5:0];
  endfunction

  // One slot: inputs driven at a falling edge, outputs checked at the next falling edge.
  task automatic step(input string tag, input bit st, input bit en, input bit pm,
                      input bit v, input logic [11:0] d);
    bit took;
    burst_start    = st;
    burst_end      = en;
    cfg_pulse_mode = pm;
    s_valid        = v;
    s_data         = d;
    check(tag, "R3 s_ready", {11'd0, s_ready}, {11'd0, m_open});
    took = v && m_open;
    @(posedge clk);
    @(negedge clk);
    if (took) begin
      check("R1", "lane_rise", {6'd0, lane_rise}, {6'd0, exp_upper(d)});
      check("R1", "lane_fall", {6'd0, lane_fall}, {6'd0, exp_lower(d)});
      check(m_pulse ? "R5" : "R4", "strobe pair", {10'd0, strb_rise, strb_fall},
            {10'd0, 1'b1, !m_pulse});
    end else begin
      check("R6", "idle lanes", {lane_rise, lane_fall}, 12'd0);
      check("R6", "idle strobe", {10'd0, strb_rise, strb_fall}, 12'd0);
    end
    if (m_open) begin
      if (en) m_open = 1'b0;
    end else if (st) begin
      m_open  = 1'b1;
      m_pulse = pm;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] w;
    void'($urandom(32'd7311));
    rst_n = 1'b0;
    s_valid = 1'b1;
    burst_start = 1'b1;
    s_data = 12'hFFF;
    repeat (3) @(negedge clk);
    check("R9", "ready in reset", {11'd0, s_ready}, 12'd0);
    check("R9", "lanes in reset", {lane_rise, lane_fall}, 12'd0);
    check("R9", "strobe in reset", {10'd0, strb_rise, strb_fall}, 12'd0);
    burst_start = 1'b0;
    s_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R8: valid and end while closed do nothing
    step("R8", 1'b0, 1'b1, 1'b0, 1'b1, 12'hABC);
    step("R8", 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
    // level burst with a contiguous run, a gap and an end-cycle word
    step("R3", 1'b1, 1'b0, 1'b0, 1'b1, 12'h123);
    step("R2", 1'b0, 1'b0, 1'b1, 1'b1, 12'hFC0);
    step("R7", 1'b0, 1'b0, 1'b1, 1'b1, 12'h03F);
    step("R8", 1'b1, 1'b0, 1'b1, 1'b1, 12'h5A5);
    step("R6", 1'b0, 1'b0, 1'b0, 1'b0, 12'hFFF);
    step("R3", 1'b0, 1'b1, 1'b0, 1'b1, 12'h801);
    step("R3", 1'b0, 1'b0, 1'b0, 1'b1, 12'h777);
    // pulse burst, mode input dropped mid-burst
    step("R7", 1'b1, 1'b0, 1'b1, 1'b0, 12'h000);
    step("R5", 1'b0, 1'b0, 1'b0, 1'b1, 12'hA5A);
    step("R7", 1'b0, 1'b0, 1'b0, 1'b1, 12'h041);
    step("R3", 1'b1, 1'b1, 1'b0, 1'b1, 12'hFFF);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b1, 12'h111);

    for (int i = 0; i < 3000; i++) begin
      w = 12'($urandom);
      step("R3", ($urandom % 8) == 0, ($urandom % 10) == 0, $urandom % 2,
           ($urandom % 4) != 0, w);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule